// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block holds the per-channel configuration word for a small DMA engine with two channels. It sits behind a single-cycle register access port that has two addresses. One is a channel-select register. The other is a window onto the control word of whichever channel that select register names. Software first picks a channel and then reads or writes its control word. The control word gives the target tightly-coupled memory, the transfer direction, the interrupt enables, the full-transfer flag, the user-mode flag, the external stride and the transaction size.

Every access carries a privilege flag. A privileged requester may always touch the control words. A user-mode requester may do so only when the selected channel's user-access bit is set; otherwise the block flags an undefined-instruction condition in the same cycle. A write is dropped while the selected channel is running or queued. The decoded fields of every channel go out to the channel engine continuously. The user-mode and interrupt-on-error outputs are the effective values, after the per-channel user-access bit and the requester's mode have been folded in.

Top module: `dmactl_bank`

## Requirements
- R1: After reset every control word is zero (data TCM, inbound, no interrupts, privileged, stride 0, byte size) and the channel select is 0.
- R2: Address 0 is the channel-select register. Its bit 0 is stored and read back with all other bits 0. It is accessible in both modes and chooses the channel that address 1 reaches.
- R3: A permitted write to address 1 stores bits 31:26, 19:8 and 1:0 of the write data into the selected channel's word. Bits 25:20 and 7:2 are stored as 0. A read of address 1 returns the stored word in the same cycle.
- R4: A user-mode access to address 1 while the selected channel's user-access bit is 0 raises acc_undef in that cycle, returns read data 0 and changes no state.
- R5: A privileged access never raises acc_undef. A user-mode access succeeds when the selected channel's user-access bit is 1.
- R6: A permitted user-mode write stores bit 26 (user mode) as 1 whatever the write data holds.
- R7: The effective user-mode output of a channel is stored bit 26 OR that channel's user-access bit.
- R8: The effective interrupt-on-error output of a channel is stored bit 28 OR that channel's user-access bit.
- R9: A write to address 1 is ignored while the selected channel's active input (running or queued) is 1. Reads still return the stored word, and other channels stay writable.
- R10: The target (bit 31), direction (bit 30), interrupt-on-completion (bit 29), full-transfer (bit 27), stride (bits 19:8) and size (bits 1:0) outputs of each channel equal those fields of its stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | 0 = channel select, 1 = control word |
| acc_user | input | 1 | 1 = user-mode requester |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, same cycle, 0 when not a permitted read |
| acc_undef | output | 1 | Undefined-instruction indication |
| ch_uacc | input | NCH | Per-channel user-access bits |
| ch_active | input | NCH | Per-channel running-or-queued state |
| cfg_target | output | NCH | Target memory, 1 = instruction TCM |
| cfg_dir | output | NCH | Direction, 1 = TCM to external memory |
| cfg_irq_done | output | NCH | Interrupt on completion |
| cfg_irq_err | output | NCH | Effective interrupt on error |
| cfg_full | output | NCH | Full transfer |
| cfg_user | output | NCH | Effective user-mode transfer |
| cfg_stride | output | 12*NCH | External stride in bytes per channel |
| cfg_size | output | 2*NCH | Transaction size per channel |

## Verification
The permission check and the busy suppression can both act on one write. This happens when a user-mode write reaches a channel that is active and whose user-access bit may or may not be set. The bench provokes this with random user-access and active patterns on every access, plus a directed user write to a busy, user-accessible channel. It judges the outcome by requiring acc_undef to follow only the permission rule, and by requiring every channel's read-back word and decoded outputs to stay unchanged whenever either rule blocks the write.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;
  localparam int WORD_W   = 32;
  localparam int STRIDE_W = 12;
  localparam int SIZE_W   = 2;
  localparam logic ADDR_SEL = 1'b0;
  localparam logic ADDR_CTL = 1'b1;
  localparam int B_TGT  = 31;
  localparam int B_DIR  = 30;
  localparam int B_IRQD = 29;
  localparam int B_IRQE = 28;
  localparam int B_FULL = 27;
  localparam int B_USER = 26;
  localparam int B_STRL = 8;
  localparam logic [WORD_W-1:0] KEEP_MASK = 32'hFC0F_FF03;

  typedef struct packed {
    logic                target;
    logic                dir;
    logic                irq_done;
    logic                irq_err;
    logic                full;
    logic                user;
    logic [STRIDE_W-1:0] stride;
    logic [SIZE_W-1:0]   size;
  } ctl_fields_t;

  // Value stored for a permitted write: reserved bits cleared, user flag
  // forced when a user-mode requester writes.
  function automatic logic [WORD_W-1:0] ctl_store(input logic [WORD_W-1:0] wd,
                                                  input logic user_wr);
    logic [WORD_W-1:0] v;
    v = wd & KEEP_MASK;
    if (user_wr) v[B_USER] = 1'b1;
    return v;
  endfunction

  // Fields seen by the channel engine, with user-access overrides applied.
  function automatic ctl_fields_t ctl_decode(input logic [WORD_W-1:0] w,
                                             input logic uacc);
    ctl_fields_t f;
    f.target   = w[B_TGT];
    f.dir      = w[B_DIR];
    f.irq_done = w[B_IRQD];
    f.irq_err  = w[B_IRQE] | uacc;
    f.full     = w[B_FULL];
    f.user     = w[B_USER] | uacc;
    f.stride   = w[B_STRL +: STRIDE_W];
    f.size     = w[SIZE_W-1:0];
    return f;
  endfunction
endpackage

// File: rtl/dmactl_access.sv
module dmactl_access
  import dmactl_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int SELW = 1
) (
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic            acc_addr,
  input  logic            acc_user,
  input  logic [NCH-1:0]  uacc,
  input  logic [NCH-1:0]  active,
  input  logic [SELW-1:0] sel,
  output logic            undef,
  output logic            sel_we,
  output logic [NCH-1:0]  ctl_we,
  output logic            rd_ctl,
  output logic            rd_sel
);
  logic ctl_acc;
  logic uacc_s;
  logic act_s;

  always_comb begin
    uacc_s  = uacc[sel];
    act_s   = active[sel];
    ctl_acc = acc_valid && (acc_addr == ADDR_CTL);
    undef   = ctl_acc && acc_user && !uacc_s;
    sel_we  = acc_valid && acc_write && (acc_addr == ADDR_SEL);
    rd_sel  = acc_valid && !acc_write && (acc_addr == ADDR_SEL);
    rd_ctl  = ctl_acc && !acc_write && !undef;
    ctl_we  = '0;
    if (ctl_acc && acc_write && !undef && !act_s) ctl_we[sel] = 1'b1;
  end
endmodule

// File: rtl/dmactl_chreg.sv
module dmactl_chreg
  import dmactl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              user_wr,
  input  logic              uacc,
  output logic [WORD_W-1:0] q,
  output ctl_fields_t       eff
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= ctl_store(wdata, user_wr);
  end

  assign eff = ctl_decode(q, uacc);
endmodule

// File: rtl/dmactl_bank.sv
module dmactl_bank
  import dmactl_pkg::*;
#(
  parameter int NCH = 2  // power of two
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic                  acc_write,
  input  logic                  acc_addr,
  input  logic                  acc_user,
  input  logic [31:0]           acc_wdata,
  output logic [31:0]           acc_rdata,
  output logic                  acc_undef,
  input  logic [NCH-1:0]        ch_uacc,
  input  logic [NCH-1:0]        ch_active,
  output logic [NCH-1:0]        cfg_target,
  output logic [NCH-1:0]        cfg_dir,
  output logic [NCH-1:0]        cfg_irq_done,
  output logic [NCH-1:0]        cfg_irq_err,
  output logic [NCH-1:0]        cfg_full,
  output logic [NCH-1:0]        cfg_user,
  output logic [12*NCH-1:0]     cfg_stride,
  output logic [2*NCH-1:0]      cfg_size
);
  localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [SELW-1:0]       sel_q;
  logic                  sel_we;
  logic                  rd_ctl;
  logic                  rd_sel;
  logic [NCH-1:0]        ctl_we;
  logic [WORD_W-1:0]     ctl_q [NCH];
  logic [NCH*WORD_W-1:0] ctl_flat;
  ctl_fields_t           eff [NCH];

  dmactl_access #(.NCH(NCH), .SELW(SELW)) acc_i (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_user  (acc_user),
    .uacc      (ch_uacc),
    .active    (ch_active),
    .sel       (sel_q),
    .undef     (acc_undef),
    .sel_we    (sel_we),
    .ctl_we    (ctl_we),
    .rd_ctl    (rd_ctl),
    .rd_sel    (rd_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_we) sel_q <= acc_wdata[SELW-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dmactl_chreg reg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (ctl_we[i]),
      .wdata   (acc_wdata),
      .user_wr (acc_user),
      .uacc    (ch_uacc[i]),
      .q       (ctl_q[i]),
      .eff     (eff[i])
    );
    assign ctl_flat[i*WORD_W +: WORD_W]     = ctl_q[i];
    assign cfg_target[i]                    = eff[i].target;
    assign cfg_dir[i]                       = eff[i].dir;
    assign cfg_irq_done[i]                  = eff[i].irq_done;
    assign cfg_irq_err[i]                   = eff[i].irq_err;
    assign cfg_full[i]                      = eff[i].full;
    assign cfg_user[i]                      = eff[i].user;
    assign cfg_stride[i*STRIDE_W +: STRIDE_W] = eff[i].stride;
    assign cfg_size[i*SIZE_W +: SIZE_W]     = eff[i].size;
  end

  always_comb begin
    acc_rdata = '0;
    if (rd_ctl)      acc_rdata = ctl_q[sel_q];
    else if (rd_sel) acc_rdata[SELW-1:0] = sel_q;
  end
endmodule

// File: rtl/dmactl_bank_chk.sv
module dmactl_bank_chk
  import dmactl_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int SELW = 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  acc_valid,
  input logic                  acc_write,
  input logic                  acc_addr,
  input logic                  acc_user,
  input logic [31:0]           acc_rdata,
  input logic                  acc_undef,
  input logic [NCH-1:0]        ch_uacc,
  input logic [NCH-1:0]        ch_active,
  input logic [SELW-1:0]       sel_q,
  input logic [NCH*WORD_W-1:0] ctl_flat,
  input logic [NCH-1:0]        cfg_irq_err,
  input logic [NCH-1:0]        cfg_user
);
  a_r4_user_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_user && acc_addr == ADDR_CTL && !ch_uacc[sel_q]) |-> acc_undef);

  a_r4_denied_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    acc_undef |-> (acc_rdata == '0));

  a_r4_denied_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_undef && acc_write) |=> $stable(ctl_flat));

  a_r5_priv_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_user) |-> !acc_undef);

  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr == ADDR_CTL && ch_active[sel_q]) |=> $stable(ctl_flat));

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_flat & ~{NCH{KEEP_MASK}}) == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_ov
    a_r7_user_forced: assert property (@(posedge clk) disable iff (!rst_n)
      ch_uacc[i] |-> cfg_user[i]);
    a_r8_err_forced: assert property (@(posedge clk) disable iff (!rst_n)
      ch_uacc[i] |-> cfg_irq_err[i]);
  end
endmodule

bind dmactl_bank dmactl_bank_chk #(.NCH(NCH), .SELW(SELW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_write   (acc_write),
  .acc_addr    (acc_addr),
  .acc_user    (acc_user),
  .acc_rdata   (acc_rdata),
  .acc_undef   (acc_undef),
  .ch_uacc     (ch_uacc),
  .ch_active   (ch_active),
  .sel_q       (sel_q),
  .ctl_flat    (ctl_flat),
  .cfg_irq_err (cfg_irq_err),
  .cfg_user    (cfg_user)
);

// File: tb/dmactl_bank_tb_top.sv
`timescale 1ns/1ps
module dmactl_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic        acc_addr = 1'b0;
  logic        acc_user = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        acc_undef;
  logic [1:0]  ch_uacc = '0;
  logic [1:0]  ch_active = '0;
  logic [1:0]  cfg_target, cfg_dir, cfg_irq_done, cfg_irq_err, cfg_full, cfg_user;
  logic [23:0] cfg_stride;
  logic [3:0]  cfg_size;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] m_ctl [2];
  logic        m_sel;

  always #4 clk = ~clk;

  dmactl_bank #(.NCH(2)) dut_i (.*);

  // Stored form of a permitted write, restated field by field.
  function automatic logic [31:0] exp_word(input logic [31:0] d, input logic u);
    return {d[31:27], d[26] | u, 6'd0, d[19:8], 6'd0, d[1:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    for (int i = 0; i < 2; i++) begin
      chk({tag, " R10 target"}, 32'(cfg_target[i]),   32'(m_ctl[i][31]));
      chk({tag, " R10 dir"},    32'(cfg_dir[i]),      32'(m_ctl[i][30]));
      chk({tag, " R10 irqd"},   32'(cfg_irq_done[i]), 32'(m_ctl[i][29]));
      chk({tag, " R8 irqe"},    32'(cfg_irq_err[i]),  32'(m_ctl[i][28] | ch_uacc[i]));
      chk({tag, " R10 full"},   32'(cfg_full[i]),     32'(m_ctl[i][27]));
      chk({tag, " R7 user"},    32'(cfg_user[i]),     32'(m_ctl[i][26] | ch_uacc[i]));
      chk({tag, " R10 stride"}, 32'(cfg_stride[i*12 +: 12]), 32'(m_ctl[i][19:8]));
      chk({tag, " R10 size"},   32'(cfg_size[i*2 +: 2]),     32'(m_ctl[i][1:0]));
    end
  endtask

  // One access: drive at the falling edge, check the same-cycle response,
  // then check the registered state after the rising edge.
  task automatic access(input string tag, input logic w, input logic a,
                        input logic [31:0] d, input logic u);
    logic e_undef;
    logic [31:0] e_rd;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_wdata = d; acc_user = u;
    #1;
    e_undef = a && u && !ch_uacc[m_sel];
    e_rd = '0;
    if (!w && !e_undef) e_rd = a ? m_ctl[m_sel] : {31'd0, m_sel};
    chk({tag, " R4/R5 undef"}, 32'(acc_undef), 32'(e_undef));
    chk({tag, " R2/R3 rdata"}, acc_rdata, e_rd);
    @(posedge clk);
    if (w && !e_undef) begin
      if (!a) m_sel = d[0];
      else if (!ch_active[m_sel]) m_ctl[m_sel] = exp_word(d, u);
    end
    #1;
    acc_valid = 1'b0;
    chk_outs(tag);
  endtask

  initial begin
    m_ctl[0] = '0; m_ctl[1] = '0; m_sel = 1'b0;
    void'($urandom(32'd7531));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk_outs("R1 reset");
    access("R1 sel", 1'b0, 1'b0, 32'h0, 1'b0);
    access("R1 ctl0", 1'b0, 1'b1, 32'h0, 1'b0);
    // R3 write with reserved bits set, read back
    access("R3 wr", 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0);
    access("R3 rd", 1'b0, 1'b1, 32'h0, 1'b0);
    // R2 select keeps only bit 0
    access("R2 wr", 1'b1, 1'b0, 32'hFFFF_FFFE, 1'b0);
    access("R2 rd", 1'b0, 1'b0, 32'h0, 1'b0);
    access("R2 wr1", 1'b1, 1'b0, 32'h0000_0003, 1'b0);
    access("R2 rd1", 1'b0, 1'b0, 32'h0, 1'b0);
    access("R10 ch1", 1'b1, 1'b1, 32'hA80A_5502, 1'b0);
    // R4 user denied on ch1
    access("R4 wr", 1'b1, 1'b1, 32'h1234_5678, 1'b1);
    access("R4 rd", 1'b0, 1'b1, 32'h0, 1'b1);
    // R5/R6 user allowed with uacc; user flag forced
    ch_uacc = 2'b10;
    access("R6 wr", 1'b1, 1'b1, 32'h4000_0101, 1'b1);
    access("R5 rd", 1'b0, 1'b1, 32'h0, 1'b1);
    // R7/R8 overrides with stored bits clear
    access("R7 clr", 1'b1, 1'b1, 32'h0, 1'b0);
    ch_uacc = 2'b11;
    access("R8 ovr", 1'b0, 1'b1, 32'h0, 1'b0);
    // R9 busy: user write to busy accessible channel, and other channel free
    ch_active = 2'b10;
    access("R9 busy", 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1);
    access("R9 rd", 1'b0, 1'b1, 32'h0, 1'b0);
    access("R9 sel0", 1'b1, 1'b0, 32'h0, 1'b0);
    access("R9 free", 1'b1, 1'b1, 32'h8C00_0F03, 1'b0);
    ch_active = 2'b00; ch_uacc = 2'b00;
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      ch_uacc   = r[1:0];
      ch_active = (r[4:2] == 3'd0) ? r[6:5] : 2'b00;
      access("RND", r[7], r[8] | r[9], $urandom, r[10] & r[11]);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule